// File: doc/BRIEF.md
# Page write buffer and sequencer

This block sits behind a two-wire serial memory slave and turns one write transaction into array updates. The bus front end gives it a starting word address, then one strobe per received data byte, then a strobe when the STOP condition ends the transaction. The bytes collect in an eight-entry page latch. No byte reaches the 128 x 8 array until STOP arrives, and then only if write protection is off and at least one byte came in.

Only the low three bits of the word address advance from byte to byte. A burst that runs past the end of its page therefore wraps to the page start. A burst longer than eight bytes overwrites the slots it filled earlier. A STOP that commits raises a busy flag for a fixed, parameterised number of clocks, which stands in for the nonvolatile programming time. While busy is high the block ignores every request from the bus side.

The array sits outside this block and is fed through a one-entry-per-clock write port. The port carries only the slots that were actually written.

Top module: `pgwr_seq`

## Requirements
- R1: After reset, busy is low, arr_we is low and cur_addr is 0.
- R2: The first byte after a start strobe is written to the start address when the transaction commits.
- R3: Each accepted byte advances bits [2:0] of the word address by one, modulo 8. Bits [6:3] stay fixed, so the writes of one burst all fall in one 8-byte page.
- R4: If more than eight bytes arrive before STOP, a later byte overwrites the slot an earlier byte filled. The array holds the last byte sent to each slot.
- R5: arr_we is never high before the STOP of its transaction. It is high only while busy is high.
- R6: A committing STOP raises busy on the next clock. Busy then stays high for exactly WR_CYCLES clocks, or for 8 clocks if WR_CYCLES is smaller than 8.
- R7: While busy is high, start, byte and stop strobes have no effect. cur_addr does not change, no extra array write happens, and the busy window is not extended.
- R8: A commit writes exactly one array location for each distinct slot written since the start strobe, and writes no others.
- R9: If wr_lock is high when STOP is accepted, busy stays low and no array write happens. The collected bytes are discarded, so a later STOP without new bytes also commits nothing.
- R10: A STOP with no data byte since the last start or commit leaves busy low and writes nothing.
- R11: After a transaction, cur_addr holds the last written address plus one, wrapped within its page.
- R12: A start strobe before STOP discards any bytes collected but not yet committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_vld | input | 1 | Load a new transaction start address |
| start_addr | input | 7 | Start word address |
| byte_vld | input | 1 | One received data byte is valid |
| byte_data | input | 8 | Received data byte |
| stop_vld | input | 1 | Transaction ended by STOP |
| wr_lock | input | 1 | Write protection, sampled with stop_vld |
| busy | output | 1 | Self-timed write window in progress |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | 7 | Array write address |
| arr_wdata | output | 8 | Array write data |
| cur_addr | output | 7 | Shared word address counter |

## Verification
A wrong page offset or a stale valid mask shows up within one busy window as a wrong location in the shadowed array, or as a wrong number of array writes. A wrong address counter shows up in cur_addr as soon as the transaction ends. A miscounted timer changes the number of busy clocks observed after the STOP. A leak through the input gating during busy shows up as a moved cur_addr or an extra write before the window closes.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
    localparam int ADDR_W     = 7;
    localparam int DATA_W     = 8;
    localparam int OFS_W      = 3;
    localparam int PAGE_BYTES = 1 << OFS_W;
    localparam int PAGE_W     = ADDR_W - OFS_W;

    typedef logic [DATA_W-1:0] byte_t;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [OFS_W-1:0]  ofs;
    } waddr_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_COMMIT,
        SQ_HOLD
    } seq_st_t;

    // advance only the in-page offset
    function automatic waddr_t bump_in_page(waddr_t a);
        waddr_t r;
        r.page = a.page;
        r.ofs  = a.ofs + 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/pgwr_latch.sv
module pgwr_latch
    import pgwr_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               load,
    input  waddr_t                             load_addr,
    input  logic                               push,
    input  byte_t                              push_data,
    input  logic                               clr,
    output waddr_t                             cur,
    output logic [PAGE_BYTES-1:0]              mask,
    output logic [PAGE_BYTES-1:0][DATA_W-1:0]  slots
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur   <= '0;
            mask  <= '0;
            slots <= '0;
        end else begin
            if (load) begin
                cur  <= load_addr;
                mask <= '0;
            end else if (push) begin
                slots[cur.ofs] <= push_data;
                mask[cur.ofs]  <= 1'b1;
                cur            <= bump_in_page(cur);
            end
            if (clr) begin
                mask <= '0;
            end
        end
    end
endmodule

// File: rtl/pgwr_timer.sv
module pgwr_timer
    import pgwr_pkg::*;
#(
    parameter int HOLD_CYC = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    output logic             busy,
    output logic             commit,
    output logic [OFS_W-1:0] slot,
    output logic             done
);
    localparam int CW = $clog2(HOLD_CYC + 1);

    seq_st_t       st;
    logic [CW-1:0] cnt;

    assign done   = (st != SQ_IDLE) && (cnt == CW'(HOLD_CYC - 1));
    assign busy   = (st != SQ_IDLE);
    assign commit = (st == SQ_COMMIT);
    assign slot   = cnt[OFS_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= SQ_IDLE;
            cnt <= '0;
        end else if (done) begin
            st  <= SQ_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                SQ_IDLE: begin
                    if (go) begin
                        st  <= SQ_COMMIT;
                        cnt <= '0;
                    end
                end
                SQ_COMMIT: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CW'(PAGE_BYTES - 1)) begin
                        st <= SQ_HOLD;
                    end
                end
                default: cnt <= cnt + 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/pgwr_seq.sv
module pgwr_seq
    import pgwr_pkg::*;
#(
    parameter int WR_CYCLES = 40000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_vld,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              stop_vld,
    input  logic              wr_lock,
    output logic              busy,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    output logic [ADDR_W-1:0] cur_addr
);
    localparam int HOLD_CYC = (WR_CYCLES < PAGE_BYTES) ? PAGE_BYTES : WR_CYCLES;

    waddr_t                            cur;
    logic [PAGE_BYTES-1:0]             mask;
    logic [PAGE_BYTES-1:0][DATA_W-1:0] slots;
    logic                              commit, done;
    logic [OFS_W-1:0]                  slot;
    logic                              load, push, stop_acc, go, clr;

    // bus side is gated off for the whole busy window
    assign load     = start_vld & ~busy;
    assign stop_acc = stop_vld & ~busy & ~start_vld;
    assign push     = byte_vld & ~busy & ~start_vld & ~stop_vld;
    assign go       = stop_acc & ~wr_lock & (|mask);
    assign clr      = done | (stop_acc & ~go);

    pgwr_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_addr (waddr_t'(start_addr)),
        .push      (push),
        .push_data (byte_data),
        .clr       (clr),
        .cur       (cur),
        .mask      (mask),
        .slots     (slots)
    );

    pgwr_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .go     (go),
        .busy   (busy),
        .commit (commit),
        .slot   (slot),
        .done   (done)
    );

    assign arr_we    = commit & mask[slot];
    assign arr_addr  = {cur.page, slot};
    assign arr_wdata = slots[slot];
    assign cur_addr  = cur;
endmodule

// File: rtl/pgwr_seq_chk.sv
module pgwr_seq_chk
    import pgwr_pkg::*;
#(
    parameter int WR_CYCLES = 40000
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_addr,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              stop_vld,
    input logic              wr_lock,
    input logic              go
);
    localparam int HOLD = (WR_CYCLES < PAGE_BYTES) ? PAGE_BYTES : WR_CYCLES;

    int run;
    always_ff @(posedge clk) begin
        if (rst)       run <= 0;
        else if (busy) run <= run + 1;
        else           run <= 0;
    end

    a_r5_we_in_busy: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> busy);

    a_r6_busy_follows_go: assert property (@(posedge clk) disable iff (rst)
        go |=> busy);

    a_r6_busy_length: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run == HOLD));

    a_r6_busy_needs_stop: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(stop_vld));

    a_r7_addr_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cur_addr));

    a_r3_same_page: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> (arr_addr[ADDR_W-1:OFS_W] == cur_addr[ADDR_W-1:OFS_W]));

    a_r9_locked_stop: assert property (@(posedge clk) disable iff (rst)
        (stop_vld && wr_lock && !busy) |=> !busy);
endmodule

bind pgwr_seq pgwr_seq_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .arr_we   (arr_we),
    .arr_addr (arr_addr),
    .cur_addr (cur_addr),
    .stop_vld (stop_vld),
    .wr_lock  (wr_lock),
    .go       (go)
);

// File: tb/pgwr_seq_test.sv
module pgwr_seq_test;
    localparam int W = 24;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_vld = 1'b0;
    logic [6:0] start_addr = '0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_data = '0;
    logic       stop_vld = 1'b0;
    logic       wr_lock = 1'b0;
    logic       busy, arr_we;
    logic [6:0] arr_addr, cur_addr;
    logic [7:0] arr_wdata;

    always #2 clk = ~clk;

    pgwr_seq #(.WR_CYCLES(W)) uut (
        .clk(clk), .rst(rst), .start_vld(start_vld), .start_addr(start_addr),
        .byte_vld(byte_vld), .byte_data(byte_data), .stop_vld(stop_vld),
        .wr_lock(wr_lock), .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr),
        .arr_wdata(arr_wdata), .cur_addr(cur_addr)
    );

    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    int busy_cnt = 0;
    logic [7:0] mem_obs [128];
    logic [7:0] mem_exp [128];

    typedef struct packed {
        logic [6:0] addr;
        logic [3:0] n;
        logic [7:0] seed;
        logic       lock;
        logic [3:0] exp_wr;
        logic       exp_busy;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{7'h10, 4'd1,  8'hA0, 1'b0, 4'd1, 1'b1},  // R2 single byte
        '{7'h0E, 4'd3,  8'h30, 1'b0, 4'd3, 1'b1},  // R3 wraps in page
        '{7'h20, 4'd8,  8'h40, 1'b0, 4'd8, 1'b1},  // R3 full page
        '{7'h45, 4'd10, 8'h60, 1'b0, 4'd8, 1'b1},  // R4 overflow
        '{7'h7F, 4'd2,  8'h90, 1'b1, 4'd0, 1'b0},  // R9 locked
        '{7'h30, 4'd0,  8'h00, 1'b0, 4'd0, 1'b0},  // R10 empty
        '{7'h7F, 4'd1,  8'hC5, 1'b0, 4'd1, 1'b1}   // R11 top of array
    };

    always @(negedge clk) begin
        if (!rst) begin
            if (arr_we) begin
                mem_obs[arr_addr] = arr_wdata;
                wr_cnt++;
            end
            if (busy) busy_cnt++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_start(input logic [6:0] a);
        @(posedge clk); #1 start_vld = 1'b1; start_addr = a;
        @(posedge clk); #1 start_vld = 1'b0;
    endtask

    task automatic pulse_byte(input logic [7:0] d);
        @(posedge clk); #1 byte_vld = 1'b1; byte_data = d;
        @(posedge clk); #1 byte_vld = 1'b0;
    endtask

    task automatic pulse_stop(input logic lk);
        @(posedge clk); #1 stop_vld = 1'b1; wr_lock = lk;
        @(posedge clk); #1 stop_vld = 1'b0; wr_lock = 1'b0;
    endtask

    task automatic settle();
        repeat (W + 6) @(negedge clk);
    endtask

    task automatic check_page(input logic [6:0] a, input string req);
        for (int k = 0; k < 8; k++) begin
            logic [6:0] x;
            x = {a[6:3], 3'(k)};
            check(mem_obs[x] === mem_exp[x], req, mem_obs[x], mem_exp[x]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R0 watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < 128; k++) begin
            mem_obs[k] = 8'h00;
            mem_exp[k] = 8'h00;
        end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(arr_we == 1'b0, "R1 we", arr_we, 0);
        check(cur_addr == 7'h00, "R1 addr", cur_addr, 0);

        for (int v = 0; v < 7; v++) begin
            vec_t t;
            t = VECS[v];
            wr_cnt = 0;
            busy_cnt = 0;
            pulse_start(t.addr);
            for (int i = 0; i < int'(t.n); i++) pulse_byte(t.seed + 8'(i));
            check(wr_cnt == 0, "R5 no write before stop", wr_cnt, 0);
            pulse_stop(t.lock);
            settle();
            if (!t.lock)
                for (int i = 0; i < int'(t.n); i++)
                    mem_exp[{t.addr[6:3], 3'(t.addr[2:0] + 3'(i))}] = t.seed + 8'(i);
            check(busy_cnt == (t.exp_busy ? W : 0), "R6/R9/R10 busy cycles", busy_cnt, t.exp_busy ? W : 0);
            check(wr_cnt == int'(t.exp_wr), "R8 write count", wr_cnt, t.exp_wr);
            check(cur_addr == {t.addr[6:3], 3'(t.addr[2:0] + t.n[2:0])}, "R11 cur_addr",
                  cur_addr, {t.addr[6:3], 3'(t.addr[2:0] + t.n[2:0])});
            check_page(t.addr, "R2/R4 page contents");
        end

        // R7: requests during busy are ignored
        wr_cnt = 0; busy_cnt = 0;
        pulse_start(7'h18);
        pulse_byte(8'h5A);
        pulse_stop(1'b0);
        pulse_start(7'h00);
        pulse_byte(8'hEE);
        pulse_stop(1'b0);
        check(cur_addr == 7'h19, "R7 addr frozen", cur_addr, 7'h19);
        settle();
        mem_exp[7'h18] = 8'h5A;
        check(busy_cnt == W, "R7 window not extended", busy_cnt, W);
        check(wr_cnt == 1, "R7 no extra write", wr_cnt, 1);
        check(mem_obs[7'h00] === mem_exp[7'h00], "R7 addr 0 untouched", mem_obs[7'h00], mem_exp[7'h00]);
        check(mem_obs[7'h18] === 8'h5A, "R7 real write", mem_obs[7'h18], 8'h5A);
        check(cur_addr == 7'h19, "R7 addr after", cur_addr, 7'h19);

        // R9: locked bytes are discarded, a bare stop later commits nothing
        wr_cnt = 0; busy_cnt = 0;
        pulse_start(7'h60);
        pulse_byte(8'h11);
        pulse_byte(8'h22);
        pulse_stop(1'b1);
        pulse_stop(1'b0);
        settle();
        check(busy_cnt == 0, "R9 no busy after lock", busy_cnt, 0);
        check(wr_cnt == 0, "R9 no write after lock", wr_cnt, 0);

        // R12: restart before stop drops the earlier bytes
        wr_cnt = 0; busy_cnt = 0;
        pulse_start(7'h50);
        pulse_byte(8'h77);
        pulse_byte(8'h78);
        pulse_start(7'h58);
        pulse_byte(8'h99);
        pulse_stop(1'b0);
        settle();
        mem_exp[7'h58] = 8'h99;
        check(wr_cnt == 1, "R12 single write", wr_cnt, 1);
        check(mem_obs[7'h50] === mem_exp[7'h50], "R12 dropped byte", mem_obs[7'h50], mem_exp[7'h50]);
        check(mem_obs[7'h58] === 8'h99, "R12 kept byte", mem_obs[7'h58], 8'h99);
        check(busy_cnt == W, "R6 busy after restart", busy_cnt, W);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule